// File: doc/BRIEF.md
# Scaled-Counter Multi-Channel PWM Timer

This block produces several pulse-width-modulated outputs from one shared free-running counter. A shift amount, set in the configuration word, picks which 16-bit window of the wide counter drives the comparators. Each step of the shift doubles the period. Every channel has its own 16-bit threshold. Its output pin is driven low while the windowed count is at or above that threshold, so the pins are active-low by nature.

Software uses a plain register port: address, write data, a write strobe and a combinational read-data bus. From there it controls the counter. It can run the counter continuously, or run it for exactly one period through a self-clearing one-shot bit. It can also make channel 0's threshold end each period early, which gives a programmable period length. Each channel has a pending flag that records when its output asserts. In sticky mode the flag is held until software rewrites it.

All register writes act from the next clock edge onward. They do not wait for a period boundary, so a period in which settings change may mix old and new values.

Top module: `pwm_scaled_timer`

## Requirements
- R1: After reset the counter is 0, the configuration word reads 0, every compare register reads 0xFFFF, and all `pwm_n` pins are high.
- R2: The counter (read/write at address 0x08) advances by one per clock while bit 12 (continuous run) or bit 13 (one-shot run) of the configuration word at 0x00 is set, and holds its value otherwise.
- R3: The windowed count, readable at 0x10, equals counter bits [scale+15 : scale], where scale is configuration bits 3:0. Writes to 0x10 are ignored.
- R4: Channel i has its compare register at 0x20 + 4*i. Its pin `pwm_n[i]` is low on the clock after the windowed count is at or above that compare value, and high otherwise. A compare value of 0 keeps the pin low, and a newly written value governs the pin from the next clock.
- R5: The one-shot bit clears itself when the windowed count wraps from a non-zero value to 0. The counter then stops at the wrapped value.
- R6: With configuration bit 9 set and the counter running, the counter returns to 0 on the clock after the windowed count reaches or passes channel 0's compare value.
- R7: Configuration bit 28+i is channel i's pending flag. With bit 8 (sticky) clear, it mirrors whether the pin is asserted. With bit 8 set, it is set when the pin asserts and is held until a configuration write loads it with 0.
- R8: Configuration bits other than 3:0, 8, 9, 12, 13 and 28 upward read as 0, and addresses that map to no register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per clock |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_n | output | NUM_CH (4) | Active-low PWM outputs, one per channel |

## Verification
The bench goes after the ends of the window range.

- At scale 15 the window is the counter's top bits. A wrong shift or slice there shows a wrong windowed count, or trips the compare one count early or late.
- A compare value of 0 must hold the pin low. A compare value of 0xFFFF must assert the pin only at the last count of the period. An off-by-one comparison would flip the pin at these edges.
- The one-shot run starts just below the wrap point. A design that cleared the bit on the wrong count, or kept counting, would leave a different counter value or a set run bit.
- The zero-compare period is watched across several periods. A missed or late reset shows up as a count above the threshold.
- Sticky pending flags are checked across the fall of their pin. A non-sticky flag that latched, or a sticky one that followed the pin, would read back wrong.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int SCALE_W = 4;

    // register map
    localparam logic [ADDR_W-1:0] A_CFG    = 8'h00;
    localparam logic [ADDR_W-1:0] A_COUNT  = 8'h08;
    localparam logic [ADDR_W-1:0] A_WINDOW = 8'h10;
    localparam int                CMP_BASE = 32'h20;
    localparam int                CMP_STEP = 4;

    // configuration word bit positions
    localparam int B_STICKY = 8;
    localparam int B_ZCRST  = 9;
    localparam int B_RUNALL = 12;
    localparam int B_RUN1   = 13;
    localparam int B_PEND   = 28;

    typedef struct packed {
        logic               run_one;
        logic               run_all;
        logic               zc_rst;
        logic               sticky;
        logic [SCALE_W-1:0] scale;
    } pwm_cfg_t;

    function automatic logic [ADDR_W-1:0] cmp_addr(input int idx);
        return ADDR_W'(CMP_BASE + CMP_STEP * idx);
    endfunction

endpackage

// File: rtl/pwm_count.sv
module pwm_count
    import pwm_timer_pkg::*;
#(
    parameter int CMP_W = 16,
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pwm_cfg_t         cfg,
    input  logic [CMP_W-1:0] cmp0,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CMP_W-1:0] window,
    output logic             period_end
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic             running;
    logic [CNT_W-1:0] cnt_inc;
    logic [CMP_W-1:0] win_now;
    logic [CMP_W-1:0] win_inc;
    logic             zc_fire;
    logic             wrap;

    always_comb begin
        st_d    = st_q;
        running = cfg.run_all | cfg.run_one;
        cnt_inc = st_q.cnt + 1'b1;
        win_now = CMP_W'(st_q.cnt >> cfg.scale);
        win_inc = CMP_W'(cnt_inc >> cfg.scale);
        zc_fire = running && cfg.zc_rst && (win_now >= cmp0);
        wrap    = running && (win_inc == '0) && (win_now != '0);
        period_end = !load_en && (zc_fire || wrap);

        if (load_en) begin
            st_d.cnt = load_val;
        end else if (zc_fire) begin
            st_d.cnt = '0;
        end else if (running) begin
            st_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt    = st_q.cnt;
    assign window = win_now;

endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp #(
    parameter int NUM_CH = 4,
    parameter int CMP_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CMP_W-1:0]             window,
    input  logic [NUM_CH-1:0][CMP_W-1:0] cmp,
    output logic [NUM_CH-1:0]            hit_nxt,
    output logic [NUM_CH-1:0]            hit_q
);

    typedef struct packed {
        logic [NUM_CH-1:0] hit;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign hit_nxt[g] = (window >= cmp[g]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.hit = hit_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_q = st_q.hit;

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CMP_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         once_done,
    input  logic [NUM_CH-1:0]            hit_nxt,
    input  logic [NUM_CH-1:0]            hit_q,
    output pwm_cfg_t                     cfg,
    output logic [NUM_CH-1:0][CMP_W-1:0] cmp,
    output logic [NUM_CH-1:0]            pend
);

    typedef struct packed {
        pwm_cfg_t                     cfg;
        logic [NUM_CH-1:0][CMP_W-1:0] cmp;
        logic [NUM_CH-1:0]            pend;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    cfg_wr;
    logic    pend_base;

    always_comb begin
        st_d      = st_q;
        cfg_wr    = we && (addr == A_CFG);
        pend_base = 1'b0;

        if (once_done) begin
            st_d.cfg.run_one = 1'b0;
        end
        if (cfg_wr) begin
            st_d.cfg.scale   = wdata[SCALE_W-1:0];
            st_d.cfg.sticky  = wdata[B_STICKY];
            st_d.cfg.zc_rst  = wdata[B_ZCRST];
            st_d.cfg.run_all = wdata[B_RUNALL];
            st_d.cfg.run_one = wdata[B_RUN1];
        end

        for (int i = 0; i < NUM_CH; i++) begin
            if (we && (addr == cmp_addr(i))) begin
                st_d.cmp[i] = wdata[CMP_W-1:0];
            end
        end

        for (int i = 0; i < NUM_CH; i++) begin
            pend_base = cfg_wr ? wdata[B_PEND + i] : st_q.pend[i];
            if (st_d.cfg.sticky) begin
                st_d.pend[i] = pend_base | (hit_nxt[i] & ~hit_q[i]);
            end else begin
                st_d.pend[i] = hit_nxt[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= '0;
            st_q.cmp  <= '1;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg  = st_q.cfg;
    assign cmp  = st_q.cmp;
    assign pend = st_q.pend;

endmodule

// File: rtl/pwm_scaled_timer.sv
module pwm_scaled_timer
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CMP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_we,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CH-1:0] pwm_n
);

    localparam int CNT_W = CMP_W + (1 << SCALE_W) - 1;

    pwm_cfg_t                     cfg_val;
    logic [NUM_CH-1:0][CMP_W-1:0] cmp_val;
    logic [NUM_CH-1:0]            pend_val;
    logic [CNT_W-1:0]             cnt_val;
    logic [CMP_W-1:0]             win_val;
    logic                         period_end;
    logic [NUM_CH-1:0]            hit_nxt;
    logic [NUM_CH-1:0]            hit_q;
    logic                         cnt_load;
    logic                         cfg_wr;
    logic                         run_en;
    logic                         once_en;
    logic                         zc_en;
    logic                         sticky_en;

    assign cnt_load  = reg_we && (reg_addr == A_COUNT);
    assign cfg_wr    = reg_we && (reg_addr == A_CFG);
    assign run_en    = cfg_val.run_all | cfg_val.run_one;
    assign once_en   = cfg_val.run_one;
    assign zc_en     = cfg_val.zc_rst;
    assign sticky_en = cfg_val.sticky;

    pwm_regs #(
        .NUM_CH (NUM_CH),
        .CMP_W  (CMP_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .once_done (period_end),
        .hit_nxt   (hit_nxt),
        .hit_q     (hit_q),
        .cfg       (cfg_val),
        .cmp       (cmp_val),
        .pend      (pend_val)
    );

    pwm_count #(
        .CMP_W (CMP_W),
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg_val),
        .cmp0       (cmp_val[0]),
        .load_en    (cnt_load),
        .load_val   (reg_wdata[CNT_W-1:0]),
        .cnt        (cnt_val),
        .window     (win_val),
        .period_end (period_end)
    );

    pwm_cmp #(
        .NUM_CH (NUM_CH),
        .CMP_W  (CMP_W)
    ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .window  (win_val),
        .cmp     (cmp_val),
        .hit_nxt (hit_nxt),
        .hit_q   (hit_q)
    );

    assign pwm_n = ~hit_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CFG) begin
            reg_rdata[SCALE_W-1:0]             = cfg_val.scale;
            reg_rdata[B_STICKY]                = cfg_val.sticky;
            reg_rdata[B_ZCRST]                 = cfg_val.zc_rst;
            reg_rdata[B_RUNALL]                = cfg_val.run_all;
            reg_rdata[B_RUN1]                  = cfg_val.run_one;
            reg_rdata[B_PEND +: NUM_CH]        = pend_val;
        end else if (reg_addr == A_COUNT) begin
            reg_rdata = DATA_W'(cnt_val);
        end else if (reg_addr == A_WINDOW) begin
            reg_rdata = DATA_W'(win_val);
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (reg_addr == cmp_addr(i)) begin
                    reg_rdata = DATA_W'(cmp_val[i]);
                end
            end
        end
    end

endmodule

// File: rtl/pwm_scaled_timer_chk.sv
module pwm_scaled_timer_chk #(
    parameter int NUM_CH = 4,
    parameter int CMP_W  = 16,
    parameter int CNT_W  = 31
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [CNT_W-1:0]             cnt,
    input logic [CMP_W-1:0]             window,
    input logic [NUM_CH-1:0][CMP_W-1:0] cmp,
    input logic [NUM_CH-1:0]            pend,
    input logic [NUM_CH-1:0]            pwm_n,
    input logic                         run_en,
    input logic                         once_en,
    input logic                         zc_en,
    input logic                         sticky_en,
    input logic                         cnt_load,
    input logic                         cfg_wr
);

    // R2: stopped counter holds its value
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !cnt_load) |=> $stable(cnt));

    // R2: running counter steps by one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !zc_en && !cnt_load) |=> (cnt == $past(cnt) + 1'b1));

    // R5: hardware clears one-shot only at a window wrap
    a_r5_once_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(once_en) && !$past(cfg_wr)) |-> (window == '0));

    // R6: zero-compare match restarts the counter
    a_r6_zc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && zc_en && !cnt_load && (window >= cmp[0])) |=> (cnt == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // R4: compare value 0 keeps the pin asserted
        a_r4_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp[g] == '0) |=> !pwm_n[g]);

        // R4: below the compare value the pin stays high
        a_r4_below_high: assert property (@(posedge clk) disable iff (!rst_n)
            (window < cmp[g]) |=> pwm_n[g]);

        // R7: sticky pending bit survives until a configuration write
        a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (sticky_en && pend[g] && !cfg_wr) |=> pend[g]);
    end

endmodule

bind pwm_scaled_timer pwm_scaled_timer_chk #(
    .NUM_CH (NUM_CH),
    .CMP_W  (CMP_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt_val),
    .window    (win_val),
    .cmp       (cmp_val),
    .pend      (pend_val),
    .pwm_n     (pwm_n),
    .run_en    (run_en),
    .once_en   (once_en),
    .zc_en     (zc_en),
    .sticky_en (sticky_en),
    .cnt_load  (cnt_load),
    .cfg_wr    (cfg_wr)
);

// File: tb/sim_pwm_scaled_timer.sv
`timescale 1ns/1ps
module sim_pwm_scaled_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic [3:0]  pwm_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_scaled_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .pwm_n     (pwm_n)
    );

    typedef struct packed {
        logic [3:0]  scale;
        logic [30:0] cnt;
        logic [15:0] cmp;
        logic [15:0] exp_win;
        logic        exp_n;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  31'h0000_0005, 16'h0005, 16'h0005, 1'b0},
        '{4'd0,  31'h0000_0004, 16'h0005, 16'h0004, 1'b1},
        '{4'd4,  31'h0000_0050, 16'h0005, 16'h0005, 1'b0},
        '{4'd4,  31'h0000_004F, 16'h0005, 16'h0004, 1'b1},
        '{4'd15, 31'h7FFF_8000, 16'hFFFF, 16'hFFFF, 1'b0},
        '{4'd15, 31'h7FFF_7FFF, 16'hFFFF, 16'hFFFE, 1'b1},
        '{4'd0,  31'h0001_2345, 16'h0000, 16'h2345, 1'b0},
        '{4'd8,  31'h0000_ABCD, 16'h00AB, 16'h00AB, 1'b0},
        '{4'd0,  31'h0000_FFFF, 16'hFFFF, 16'hFFFF, 1'b0},
        '{4'd3,  31'h0000_0000, 16'h0001, 16'h0000, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a, b;
        logic [31:0] peak;
        bit          saw_restart;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pins", {28'd0, pwm_n}, 32'hF);
        rd(8'h00, v); chk("R1 cfg", v, 32'h0);
        rd(8'h08, v); chk("R1 count", v, 32'h0);
        rd(8'h20, v); chk("R1 cmp0", v, 32'hFFFF);
        rd(8'h2C, v); chk("R1 cmp3", v, 32'hFFFF);

        // R3 / R4 vector table: window slice and compare threshold
        for (int i = 0; i < NV; i++) begin
            wr(8'h00, {28'd0, VECS[i].scale});
            wr(8'h20, {16'd0, VECS[i].cmp});
            wr(8'h08, {1'b0, VECS[i].cnt});
            @(negedge clk);
            chk($sformatf("R4 pin vec%0d", i), {31'd0, pwm_n[0]}, {31'd0, VECS[i].exp_n});
            rd(8'h10, v);
            chk($sformatf("R3 window vec%0d", i), v, {16'd0, VECS[i].exp_win});
        end

        // R3 writes to the window address are ignored
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h1234);
        wr(8'h10, 32'hFFFF);
        rd(8'h08, v); chk("R3 window write ignored count", v, 32'h1234);
        rd(8'h10, v); chk("R3 window write ignored window", v, 32'h1234);

        // R2 counter runs in continuous mode, holds when stopped
        wr(8'h08, 32'h0);
        wr(8'h00, 32'h1000);
        @(negedge clk);
        rd(8'h08, a);
        repeat (10) @(negedge clk);
        rd(8'h08, b);
        chk("R2 advance", b - a, 32'd10);
        wr(8'h00, 32'h0);
        rd(8'h08, a);
        repeat (5) @(negedge clk);
        rd(8'h08, b);
        chk("R2 hold", b, a);

        // R5 one-shot stops at the wrap and clears itself
        wr(8'h08, 32'hFFF0);
        wr(8'h00, 32'h2000);
        repeat (40) @(negedge clk);
        rd(8'h08, v); chk("R5 stop count", v, 32'h0001_0000);
        rd(8'h00, v); chk("R5 bit cleared", v, 32'h0);

        // R6 zero-compare restart with threshold 9
        wr(8'h08, 32'h0);
        wr(8'h20, 32'd9);
        wr(8'h00, 32'h1200);
        peak = 0;
        saw_restart = 1'b0;
        reg_addr = 8'h08;
        #1 a = reg_rdata;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            #1 b = reg_rdata;
            if (b > peak) peak = b;
            if (a == 32'd9 && b == 32'd0) saw_restart = 1'b1;
            a = b;
        end
        chk("R6 peak count", peak, 32'd9);
        chk("R6 restart seen", {31'd0, saw_restart}, 32'd1);
        wr(8'h00, 32'h0);

        // R7 sticky pending flag on channel 1 (bit 29)
        wr(8'h24, 32'h0010);
        wr(8'h08, 32'h000F);
        wr(8'h00, 32'h0100);
        @(negedge clk);
        rd(8'h00, v); chk("R7 sticky idle", {31'd0, v[29]}, 32'd0);
        wr(8'h08, 32'h0010);
        @(negedge clk);
        rd(8'h00, v); chk("R7 sticky set", {31'd0, v[29]}, 32'd1);
        wr(8'h08, 32'h000F);
        @(negedge clk);
        chk("R7 pin released", {31'd0, pwm_n[1]}, 32'd1);
        rd(8'h00, v); chk("R7 sticky held", {31'd0, v[29]}, 32'd1);
        wr(8'h00, 32'h0100);
        rd(8'h00, v); chk("R7 sticky cleared", {31'd0, v[29]}, 32'd0);
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h0010);
        @(negedge clk);
        rd(8'h00, v); chk("R7 mirror high", {31'd0, v[29]}, 32'd1);
        wr(8'h08, 32'h000F);
        @(negedge clk);
        rd(8'h00, v); chk("R7 mirror low", {31'd0, v[29]}, 32'd0);

        // R8 unimplemented bits and unmapped address read zero
        wr(8'h20, 32'hFFFF);
        wr(8'h08, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R8 cfg readback", v, 32'hF000_330F);
        rd(8'h04, v); chk("R8 unmapped", v, 32'h0);
        wr(8'h00, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule